// File: doc/BRIEF.md
# Management Data Frame Master

This block is a clause-22 style management-interface master. It turns one host request into a serial frame on a management clock output, a data output with its own output enable, and a separate data input. The host supplies an operation bit, an 11-bit device address and 16 bits of write data. When the transfer has finished, the block returns the 16-bit read data and a flag that shows no target answered. The management clock half-period is a programmable number of system clocks.

The device address is split inside the block. Bits 9..5 become the 5-bit target field and bits 4..0 become the 5-bit register field. Bit 10 only takes part in the threshold comparison. Reads at or above a fixed threshold (0x300) go through a slow path on the target, and the first answer from that path cannot be trusted. Such a read therefore runs two complete frames back to back and keeps only the second answer. If the target does not pull the line low during turnaround, the block clocks a recovery burst, returns all ones and raises the absent flag.

Top module: `mdio_master`

## Requirements
- R1: Out of reset and whenever idle, `mdc` is low, `mdo_oe` is low, `busy` is low and `done` is low.
- R2: Each frame bit is one `mdc` period: a low phase and then a high phase, each `half_div` system clocks long. A `half_div` of 0 acts as 1. `mdo` and `mdo_oe` change only while `mdc` is low. `mdi` is sampled at the rising edge of `mdc`.
- R3: Every frame starts with 32 bits of `mdo` = 1. Then come the start bits 0,1 and the opcode bits: 1,0 for a read (`wr`=0) and 0,1 for a write (`wr`=1).
- R4: After the opcode, the target field `addr[9:5]` is sent MSB first, followed by the register field `addr[4:0]` MSB first.
- R5: A write frame drives turnaround bits 1,0, then `wdata` MSB first. On the 65th bit it releases the line (`mdo_oe`=0) and gives one more clock, so the frame is 65 bits long.
- R6: A read frame releases the line from bit 46 onward and clocks two turnaround bits. It then samples 16 data bits MSB first and ends with one trailing clock (65 bits). The result appears on `rd_data`.
- R7: If the `mdi` sample at the second turnaround bit (bit 47) is 1, the frame clocks 32 further bits after the turnaround, 80 bits in all. The transfer then returns `rd_data` = 0xFFFF with `absent` = 1. A normal completion returns `absent` = 0.
- R8: A read with `addr` >= 0x300 runs two frames back to back and returns only the result of the second frame. Writes at such addresses use a single frame.
- R9: `done` is a one-cycle pulse. It is due 2·half_div·(total frame bits) clocks after the clock edge that accepted the request. `rd_data` and `absent` are valid with `done` and hold until the next completion.
- R10: `busy` rises on the edge after a request (`req` high while `busy` is low) and falls with `done`. A request made while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | Start a transfer when not busy |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 11 | Device address (target = bits 9..5, register = bits 4..0) |
| wdata | input | 16 | Write data |
| half_div | input | 8 | Management clock half-period in system clocks (0 treated as 1) |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Read result |
| absent | output | 1 | Target failed the turnaround check |
| mdc | output | 1 | Management clock |
| mdo | output | 1 | Serial data out |
| mdo_oe | output | 1 | Output enable for `mdo` |
| mdi | input | 1 | Serial data in |

## Verification
Every result is due a fixed number of clocks after the accepting edge: 130·D for a normal frame and 160·D for a frame with an absent target, where D is the effective half-period. The count doubles for a read above the threshold. The bench counts falling system-clock edges from acceptance until `done` is seen and compares that count with the value worked out from the mode, the address and D. The bench target model takes frame fields and output-enable levels at each rising edge of `mdc` and changes `mdi` only after a falling edge. As a result, turnaround and data values are settled a whole low phase before the block samples them.

// File: rtl/mdio_pkg.sv
// Shared constants and frame-word layout for the management frame master.
// Assumes a 32-bit preamble, then a 32-bit word holding start, opcode, target,
// register, turnaround and data fields in transmit order.
package mdio_pkg;
    localparam int BIT_W    = 7;
    localparam int DATA_W   = 16;
    localparam int FIELD_W  = 5;

    // Bit positions within a frame (bit 0 is the first preamble bit)
    localparam logic [BIT_W-1:0] B_WORD_FIRST = 7'd32;
    localparam logic [BIT_W-1:0] B_RA_LAST    = 7'd45;
    localparam logic [BIT_W-1:0] B_TA2        = 7'd47;
    localparam logic [BIT_W-1:0] B_DATA_FIRST = 7'd48;
    localparam logic [BIT_W-1:0] B_DATA_LAST  = 7'd63;
    localparam logic [BIT_W-1:0] B_TRAIL      = 7'd64;
    localparam logic [BIT_W-1:0] B_RECOV_LAST = 7'd79;

    typedef struct packed {
        logic [1:0]         st;
        logic [1:0]         op;
        logic [FIELD_W-1:0] pa;
        logic [FIELD_W-1:0] ra;
        logic [1:0]         ta;
        logic [DATA_W-1:0]  data;
    } frame_word_t;
endpackage

// File: rtl/mdio_clk_div.sv
// Management clock generator. While run is high it produces a clock whose low
// and high phases each last half_div system clocks (0 acts as 1). It also
// raises strobes on the cycle of each rising edge and of each bit end.
// Assumes run falls only on a bit-end strobe.
module mdio_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             mdc,
    output logic             rise_stb,
    output logic             bit_end_stb
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] last_cnt;
    logic             phase_end;

    // Terminal count of one phase
    always_comb begin
        last_cnt  = (half_div == '0) ? '0 : half_div - DIV_W'(1);
        phase_end = (cnt == last_cnt);
        rise_stb    = run && !mdc && phase_end;
        bit_end_stb = run &&  mdc && phase_end;
    end

    // Phase counter and clock toggle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (phase_end) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end

    // R1
    mdc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc);
    // R2
    mdc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !rise_stb && !bit_end_stb) |=> $stable(mdc));
endmodule

// File: rtl/mdio_frame_seq.sv
// Frame sequencer. It counts bits, takes the turnaround and data samples,
// stretches a frame by the recovery burst when the target is absent, and
// repeats the frame once for a two-frame read. Assumes is_read and
// two_frames are stable while run is high.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_read,
    input  logic              two_frames,
    input  logic              rise_stb,
    input  logic              bit_end_stb,
    input  logic              mdi,
    output logic              run,
    output logic [BIT_W-1:0]  bit_idx,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              absent
);
    logic              second;
    logic              miss;
    logic [DATA_W-1:0] sh;
    logic [BIT_W-1:0]  last_bit;

    // Last bit of the current frame
    always_comb last_bit = miss ? B_RECOV_LAST : B_TRAIL;

    // Bit counter, sampling and completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run     <= 1'b0;
            bit_idx <= '0;
            second  <= 1'b0;
            miss    <= 1'b0;
            sh      <= '0;
            done    <= 1'b0;
            rd_data <= '0;
            absent  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!run) begin
                if (start) begin
                    run     <= 1'b1;
                    bit_idx <= '0;
                    second  <= 1'b0;
                    miss    <= 1'b0;
                end
            end else begin
                if (rise_stb && is_read) begin
                    if (bit_idx == B_TA2)
                        miss <= mdi;
                    else if (bit_idx >= B_DATA_FIRST && bit_idx <= B_DATA_LAST)
                        sh <= {sh[DATA_W-2:0], mdi};
                end
                if (bit_end_stb) begin
                    if (bit_idx == last_bit) begin
                        if (two_frames && !second) begin
                            second  <= 1'b1;
                            bit_idx <= '0;
                            miss    <= 1'b0;
                        end else begin
                            run    <= 1'b0;
                            done   <= 1'b1;
                            absent <= miss;
                            if (is_read)
                                rd_data <= miss ? '1 : sh;
                        end
                    end else begin
                        bit_idx <= bit_idx + BIT_W'(1);
                    end
                end
            end
        end
    end

    // R7
    absent_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && absent) |-> (rd_data == '1));
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7
    bit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (bit_idx <= B_RECOV_LAST));
    // R10
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !run);
endmodule

// File: rtl/mdio_master.sv
// Top of the management frame master. It accepts one request at a time,
// splits the device address into target and register fields, builds the
// transmit word and drives the serial output and its enable from the bit
// position. Assumes ADDR_W >= 2*FIELD_W.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int          ADDR_W           = 11,
    parameter int          DIV_W            = 8,
    parameter int unsigned SECOND_READ_FROM = 'h300
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DIV_W-1:0]  half_div,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              absent,
    output logic              mdc,
    output logic              mdo,
    output logic              mdo_oe,
    input  logic              mdi
);
    logic              run;
    logic              start;
    logic              rise_stb;
    logic              bit_end_stb;
    logic [BIT_W-1:0]  bit_idx;
    logic              wr_q;
    logic              two_q;
    frame_word_t       word_q;
    logic [31:0]       tx_word;

    assign busy    = run;
    assign start   = req && !run;
    assign tx_word = word_q;

    // Capture the request and build the transmit word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            two_q  <= 1'b0;
            word_q <= '0;
        end else if (start) begin
            wr_q        <= wr;
            two_q       <= !wr && (addr >= ADDR_W'(SECOND_READ_FROM));
            word_q.st   <= 2'b01;
            word_q.op   <= wr ? 2'b01 : 2'b10;
            word_q.pa   <= addr[FIELD_W +: FIELD_W];
            word_q.ra   <= addr[FIELD_W-1:0];
            word_q.ta   <= 2'b10;
            word_q.data <= wdata;
        end
    end

    // Serial output value and enable by bit position
    always_comb begin
        mdo    = 1'b1;
        mdo_oe = 1'b0;
        if (run) begin
            if (bit_idx >= B_WORD_FIRST && bit_idx <= B_DATA_LAST)
                mdo = tx_word[5'(B_DATA_LAST - bit_idx)];
            mdo_oe = wr_q ? (bit_idx <= B_DATA_LAST) : (bit_idx <= B_RA_LAST);
        end
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .half_div    (half_div),
        .mdc         (mdc),
        .rise_stb    (rise_stb),
        .bit_end_stb (bit_end_stb)
    );

    mdio_frame_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .is_read     (!wr_q),
        .two_frames  (two_q),
        .rise_stb    (rise_stb),
        .bit_end_stb (bit_end_stb),
        .mdi         (mdi),
        .run         (run),
        .bit_idx     (bit_idx),
        .done        (done),
        .rd_data     (rd_data),
        .absent      (absent)
    );

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdo_oe));
    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !busy) |=> busy);
endmodule

// File: tb/mdio_master_bench.sv
// Bench with a behavioural target model. It sweeps addresses, data, modes and
// divider values and computes every expected value arithmetically.
module mdio_master_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        wr = 1'b0;
    logic [10:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [7:0]  half_div = 8'd1;
    logic        busy, done, absent, mdc, mdo, mdo_oe;
    logic [15:0] rd_data;
    logic        mdi = 1'b1;

    int total = 0;
    int fails = 0;

    // target model state
    logic [15:0] mem [0:1023];
    logic        phy_present = 1'b1;
    logic        cur_w = 1'b0;
    logic        cur_two = 1'b0;
    logic [10:0] cur_a = '0;
    int          rise_k = 0;
    int          frame_in_txn = 0;
    logic [31:0] cap = '0;
    logic        mdc_d = 1'b0, mdo_d = 1'b1, oe_d = 1'b0;
    logic        pre_bad, hdr_bad, addr_bad, oe_bad, ta_bad, edge_bad;

    always #10 clk = ~clk;

    mdio_master u_mdio_master (
        .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr),
        .wdata(wdata), .half_div(half_div), .busy(busy), .done(done),
        .rd_data(rd_data), .absent(absent), .mdc(mdc), .mdo(mdo),
        .mdo_oe(mdo_oe), .mdi(mdi)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", tag, act, exp);
        end
    endtask

    // Target model: samples at mdc rises, drives mdi after mdc falls
    always @(negedge clk) begin
        if (!busy) begin
            rise_k = 0;
            mdi = 1'b1;
        end else begin
            if (mdc && !mdc_d) begin
                if (phy_present) begin
                    if (rise_k < 32 && mdo !== 1'b1) pre_bad = 1'b1;
                    if (rise_k <= 45 && mdo_oe !== 1'b1) oe_bad = 1'b1;
                    if (rise_k >= 46 && rise_k <= 63 && mdo_oe !== cur_w) oe_bad = 1'b1;
                    if (rise_k == 64 && mdo_oe !== 1'b0) oe_bad = 1'b1;
                    if (rise_k == 46) begin
                        frame_in_txn++;
                        if (cap[13:12] !== 2'b01 || cap[11:10] !== (cur_w ? 2'b01 : 2'b10))
                            hdr_bad = 1'b1;
                        if (cap[9:0] !== cur_a[9:0]) addr_bad = 1'b1;
                    end
                    if (rise_k == 64 && cur_w) begin
                        mem[cap[27:18]] = cap[15:0];
                        if (cap[17:16] !== 2'b10) ta_bad = 1'b1;
                    end
                end
                if (rise_k >= 32 && rise_k <= 63) cap = {cap[30:0], mdo};
                rise_k = (rise_k == 64) ? 0 : rise_k + 1;
            end
            if (!mdc && mdc_d) begin
                logic [15:0] dout;
                dout = mem[cur_a[9:0]];
                if (cur_two && frame_in_txn == 1) dout = ~dout;
                if (!phy_present || cur_w) mdi = 1'b1;
                else if (rise_k == 47) mdi = 1'b0;
                else if (rise_k >= 48 && rise_k <= 63) mdi = dout[63 - rise_k];
                else mdi = 1'b1;
            end
            if (mdc && mdc_d && (mdo !== mdo_d || mdo_oe !== oe_d)) edge_bad = 1'b1;
        end
        mdc_d = mdc;
        mdo_d = mdo;
        oe_d  = mdo_oe;
    end

    task automatic xfer(input logic w, input logic [10:0] a, input logic [15:0] d,
                        input int dv, input logic present, input logic intrude);
        int n;
        int eff;
        int bits;
        int frames;
        int exp_n;
        logic [15:0] exp_rd;
        @(negedge clk);
        phy_present = present;
        half_div = 8'(dv);
        cur_w = w; cur_a = a; cur_two = !w && (a >= 11'h300);
        frame_in_txn = 0;
        pre_bad = 0; hdr_bad = 0; addr_bad = 0; oe_bad = 0; ta_bad = 0; edge_bad = 0;
        exp_rd = mem[a[9:0]];
        req = 1'b1; wr = w; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0;
        check("R10 busy after accept", busy, 1);
        n = 0;
        while (!done && n < 5000) begin
            @(negedge clk);
            n++;
            if (intrude && n == 5) begin
                req = 1'b1; wr = 1'b1; addr = 11'h055; wdata = 16'hDEAD;
            end
            if (intrude && n == 9) req = 1'b0;
        end
        eff = (dv == 0) ? 1 : dv;
        bits = (!w && !present) ? 80 : 65;
        frames = cur_two ? 2 : 1;
        exp_n = 2 * eff * bits * frames;
        check("R9 done latency", n, exp_n);
        check("R2 output stable while mdc high", edge_bad, 0);
        if (present) begin
            check("R3 preamble", pre_bad, 0);
            check("R3 start/opcode", hdr_bad, 0);
            check("R4 target/register fields", addr_bad, 0);
        end
        if (w) begin
            check("R5 output enable", oe_bad, 0);
            check("R5 turnaround", ta_bad, 0);
            check("R5 stored data", mem[a[9:0]], d);
            check("R7 absent low after write", absent, 0);
        end else if (present) begin
            check("R6 release", oe_bad, 0);
            check("R8 frame count", frame_in_txn, frames);
            if (cur_two) check("R8 second result", rd_data, exp_rd);
            else         check("R6 read data", rd_data, exp_rd);
            check("R7 absent low", absent, 0);
        end else begin
            check("R7 all ones", rd_data, 16'hFFFF);
            check("R7 absent high", absent, 1);
        end
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end

    initial begin
        logic [10:0] alist [6];
        logic [15:0] keep;
        alist = '{11'h000, 11'h01F, 11'h020, 11'h2A5, 11'h300, 11'h3FF};
        for (int i = 0; i < 1024; i++) mem[i] = 16'(i * 40503) ^ 16'h5A5A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mdc idle", mdc, 0);
        check("R1 mdo_oe idle", mdo_oe, 0);
        check("R1 busy idle", busy, 0);
        check("R1 done idle", done, 0);

        for (int dv = 1; dv <= 3; dv++) begin
            for (int i = 0; i < 6; i++)
                xfer(1'b1, alist[i], 16'(alist[i] * 499) ^ 16'(dv << 12) ^ 16'hA5C3, dv, 1'b1, 1'b0);
            for (int i = 0; i < 6; i++)
                xfer(1'b0, alist[i], 16'h0, dv, 1'b1, 1'b0);
        end
        xfer(1'b0, 11'h7E0, 16'h0, 2, 1'b1, 1'b0);
        xfer(1'b0, 11'h00A, 16'h0, 1, 1'b0, 1'b0);
        xfer(1'b0, 11'h301, 16'h0, 1, 1'b0, 1'b0);
        xfer(1'b0, 11'h00A, 16'h0, 1, 1'b1, 1'b0);
        xfer(1'b1, 11'h123, 16'hC0DE, 0, 1'b1, 1'b0);
        xfer(1'b0, 11'h123, 16'h0, 0, 1'b1, 1'b0);

        keep = mem[10'h055];
        xfer(1'b0, 11'h0F0, 16'h0, 2, 1'b1, 1'b1);
        check("R10 ignored request left target untouched", mem[10'h055], keep);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            check("R10 no queued transfer", busy, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
        $finish;
    end
endmodule